// File: doc/BRIEF.md
# PHY Configuration Register Bridge

This block gives a host a window onto the configuration registers inside a serial-link PHY. The PHY registers are never mapped directly. Software loads a data word into a staging register, enables the lane, and writes a command word that holds a PHY register address, a group select bit and one of two direction bits. The bridge turns that command into a request/done handshake on a narrow PHY-side port. When the PHY reports completion, the bridge raises a sticky acknowledge flag that software polls. For reads, it also captures the PHY's answer into a read-back register.

Each access ends when software writes zero to the command register. That clears the acknowledge flag and frees the bridge for the next command. A separate reset register drives the PHY's hard and soft reset lines. While the hard reset line is held, the bridge forwards nothing and aborts any access in flight.

Host register indices (host_addr): 0 command, 1 write staging, 2 lane enable, 3 PHY reset, 4 read-back, 5 acknowledge. Command word fields: bits 7:0 hold the PHY register address, bit 8 requests a write, bit 9 requests a read, bit 10 selects the alternate register group.

Top module: `phy_cfg_bridge`

## Requirements
- R1: After reset, all six host registers read zero, phy_req is low, and both PHY reset outputs are low.
- R2: A command write with bit 8 set (a write) raises phy_req with phy_wr=1. The request carries phy_addr = command bits 7:0, phy_grp = command bit 10, and phy_wdata = the write staging register.
- R3: For a read command (bit 9), the value on phy_rdata in the cycle phy_done is seen is captured into the read-back register (index 4). That register changes at no other time.
- R4: phy_req stays high until phy_done is seen. In the following cycle phy_req is low and bit 0 of the acknowledge register (index 5) is 1.
- R5: The acknowledge bit stays set until the command register is written with zero. After that write it reads 0 and a new command is accepted.
- R6: A command word with both bits 8 and 9 set, or with neither set, issues no request and leaves the acknowledge bit at 0.
- R7: A command written while lane enable (index 2, bit 0) is clear issues no request.
- R8: While the PHY hard reset bit (index 3, bit 1) is set, commands are not forwarded and the acknowledge bit stays 0. Setting the bit during an access drops phy_req without setting the acknowledge bit.
- R9: Index 3 bit 1 drives phy_rst_hard and bit 0 drives phy_rst_soft, one cycle after the host write.
- R10: A nonzero command written while an access is pending or acknowledged is not forwarded. It changes neither the acknowledge bit nor the read-back register.
- R11: Accesses to the same PHY address in the two register groups reach separate registers: a write in one group does not change what a read in the other group returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data for host_addr |
| phy_req | output | 1 | Access request held until phy_done |
| phy_wr | output | 1 | 1 = write access, 0 = read access |
| phy_grp | output | 1 | Register group select |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 32 | PHY write data |
| phy_lane | output | 1 | Lane enable to the PHY |
| phy_rdata | input | 32 | PHY read data, valid with phy_done |
| phy_done | input | 1 | One-cycle completion pulse from the PHY |
| phy_rst_hard | output | 1 | PHY hard reset |
| phy_rst_soft | output | 1 | PHY soft reset |

## Verification
The bench runs the PHY with latencies from zero to many cycles. This catches a bridge that drops its request early or samples read data at the wrong cycle; such a bridge would return stale or zero read-back values. It writes a second command while the acknowledge flag is still set: a bridge that re-arms without the zero write would start a fresh PHY access and overwrite the read-back register. It sends malformed command words with both or neither direction bit, which a naive decoder would forward as a write or a read. It raises the hard reset in the middle of an access, where a faulty design would leave the request stuck high or later raise an acknowledge that software never asked for.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int HIDX_W = 3;

  localparam logic [HIDX_W-1:0] IDX_CMD   = 3'd0;
  localparam logic [HIDX_W-1:0] IDX_WDATA = 3'd1;
  localparam logic [HIDX_W-1:0] IDX_LANE  = 3'd2;
  localparam logic [HIDX_W-1:0] IDX_RST   = 3'd3;
  localparam logic [HIDX_W-1:0] IDX_RDATA = 3'd4;
  localparam logic [HIDX_W-1:0] IDX_ACK   = 3'd5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/phy_bridge_regs.sv
module phy_bridge_regs
  import phy_bridge_pkg::*;
#(
  parameter int PHY_ADDR_W = 8,
  parameter int DATA_W     = 32,
  localparam int CMD_W     = PHY_ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [HIDX_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] rd_capture,
  input  logic              ack,
  output logic              cmd_we,
  output logic              cmd_zero,
  output logic [CMD_W-1:0]  cmd_val,
  output logic [DATA_W-1:0] wdata_q,
  output logic              lane_q,
  output logic              hard_rst_q,
  output logic              soft_rst_q
);
  logic [CMD_W-1:0] cmd_q;

  assign cmd_we   = host_we && (host_addr == IDX_CMD);
  assign cmd_val  = host_wdata[CMD_W-1:0];
  assign cmd_zero = (host_wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      wdata_q    <= '0;
      lane_q     <= 1'b0;
      hard_rst_q <= 1'b0;
      soft_rst_q <= 1'b0;
    end else if (host_we) begin
      case (host_addr)
        IDX_CMD:   cmd_q   <= host_wdata[CMD_W-1:0];
        IDX_WDATA: wdata_q <= host_wdata;
        IDX_LANE:  lane_q  <= host_wdata[0];
        IDX_RST: begin
          hard_rst_q <= host_wdata[1];
          soft_rst_q <= host_wdata[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        IDX_CMD:   host_rdata <= DATA_W'(cmd_q);
        IDX_WDATA: host_rdata <= wdata_q;
        IDX_LANE:  host_rdata <= DATA_W'(lane_q);
        IDX_RST:   host_rdata <= DATA_W'({hard_rst_q, soft_rst_q});
        IDX_RDATA: host_rdata <= rd_capture;
        IDX_ACK:   host_rdata <= DATA_W'(ack);
        default:   host_rdata <= '0;
      endcase
    end
  end

  assert_rst_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == IDX_RST) |=> (hard_rst_q == $past(host_wdata[1])));
endmodule

// File: rtl/phy_bridge_seq.sv
module phy_bridge_seq
  import phy_bridge_pkg::*;
#(
  parameter int PHY_ADDR_W = 8,
  parameter int DATA_W     = 32,
  localparam int CMD_W     = PHY_ADDR_W + 3,
  localparam int WR_BIT    = PHY_ADDR_W,
  localparam int RD_BIT    = PHY_ADDR_W + 1,
  localparam int GRP_BIT   = PHY_ADDR_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_we,
  input  logic                  cmd_zero,
  input  logic [CMD_W-1:0]      cmd_val,
  input  logic [DATA_W-1:0]     wdata_q,
  input  logic                  lane_q,
  input  logic                  hard_rst_q,
  output logic                  phy_req,
  output logic                  phy_wr,
  output logic                  phy_grp,
  output logic [PHY_ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0]     phy_wdata,
  input  logic [DATA_W-1:0]     phy_rdata,
  input  logic                  phy_done,
  output logic                  ack,
  output logic [DATA_W-1:0]     rd_capture
);
  seq_state_t state;
  logic       cmd_legal;

  assign cmd_legal = cmd_val[WR_BIT] ^ cmd_val[RD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      phy_req    <= 1'b0;
      phy_wr     <= 1'b0;
      phy_grp    <= 1'b0;
      phy_addr   <= '0;
      phy_wdata  <= '0;
      ack        <= 1'b0;
      rd_capture <= '0;
    end else if (hard_rst_q) begin
      state   <= SEQ_IDLE;
      phy_req <= 1'b0;
      ack     <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (cmd_we && lane_q && cmd_legal) begin
            state     <= SEQ_BUSY;
            phy_req   <= 1'b1;
            phy_wr    <= cmd_val[WR_BIT];
            phy_grp   <= cmd_val[GRP_BIT];
            phy_addr  <= cmd_val[PHY_ADDR_W-1:0];
            phy_wdata <= wdata_q;
          end
        end
        SEQ_BUSY: begin
          if (phy_done) begin
            state   <= SEQ_DONE;
            phy_req <= 1'b0;
            ack     <= 1'b1;
            if (!phy_wr) rd_capture <= phy_rdata;
          end
        end
        SEQ_DONE: begin
          if (cmd_we && cmd_zero) begin
            state <= SEQ_IDLE;
            ack   <= 1'b0;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_done && !hard_rst_q) |=> phy_req);

  assert_ack_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ack && !(cmd_we && cmd_zero) && !hard_rst_q) |=> ack);

  assert_legal_issue_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_req) |-> ($past(cmd_we) && $countones($past(cmd_val[RD_BIT:WR_BIT])) == 1));

  assert_capture_only_done_R3: assert property (@(posedge clk) disable iff (rst)
    !(phy_req && phy_done) |=> $stable(rd_capture));

  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    hard_rst_q |=> (!ack && !phy_req));

  assert_lane_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_req) |-> $past(lane_q));
endmodule

// File: rtl/phy_cfg_bridge.sv
module phy_cfg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int PHY_ADDR_W = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_we,
  input  logic [HIDX_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  phy_req,
  output logic                  phy_wr,
  output logic                  phy_grp,
  output logic [PHY_ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0]     phy_wdata,
  output logic                  phy_lane,
  input  logic [DATA_W-1:0]     phy_rdata,
  input  logic                  phy_done,
  output logic                  phy_rst_hard,
  output logic                  phy_rst_soft
);
  localparam int CMD_W = PHY_ADDR_W + 3;

  logic              cmd_we, cmd_zero, lane_q, hard_q, soft_q, ack;
  logic [CMD_W-1:0]  cmd_val;
  logic [DATA_W-1:0] wdata_q, rd_capture;

  phy_bridge_regs #(.PHY_ADDR_W(PHY_ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .rd_capture(rd_capture), .ack(ack),
    .cmd_we(cmd_we), .cmd_zero(cmd_zero), .cmd_val(cmd_val),
    .wdata_q(wdata_q), .lane_q(lane_q),
    .hard_rst_q(hard_q), .soft_rst_q(soft_q)
  );

  phy_bridge_seq #(.PHY_ADDR_W(PHY_ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_we(cmd_we), .cmd_zero(cmd_zero), .cmd_val(cmd_val),
    .wdata_q(wdata_q), .lane_q(lane_q), .hard_rst_q(hard_q),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_grp(phy_grp),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_rdata(phy_rdata), .phy_done(phy_done),
    .ack(ack), .rd_capture(rd_capture)
  );

  assign phy_lane     = lane_q;
  assign phy_rst_hard = hard_q;
  assign phy_rst_soft = soft_q;
endmodule

// File: tb/phy_cfg_bridge_test.sv
module phy_cfg_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_wr, phy_grp, phy_lane, phy_rst_hard, phy_rst_soft;
  logic [7:0]  phy_addr;
  logic [31:0] phy_wdata;
  logic [31:0] phy_rdata = '0;
  logic        phy_done = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 0;

  phy_cfg_bridge uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_grp(phy_grp), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_lane(phy_lane), .phy_rdata(phy_rdata),
    .phy_done(phy_done), .phy_rst_hard(phy_rst_hard), .phy_rst_soft(phy_rst_soft)
  );

  always #2 clk = ~clk;

  // PHY model: two register groups, variable latency
  logic [31:0] mem [512];
  logic        pend = 1'b0;
  int          cnt = 0;
  initial for (int i = 0; i < 512; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (phy_done) phy_done <= 1'b0;
    else if (!phy_req) pend <= 1'b0;
    else if (!pend) begin pend <= 1'b1; cnt <= lat; end
    else if (cnt == 0) begin
      phy_done  <= 1'b1;
      pend      <= 1'b0;
      phy_rdata <= mem[{phy_grp, phy_addr}];
      if (phy_wr) mem[{phy_grp, phy_addr}] <= phy_wdata;
    end else cnt <= cnt - 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = idx; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic hrd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = idx;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_ack(input string req, output logic ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      hrd(3'd5, v);
      if (v[0]) begin ok = 1'b1; break; end
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  task automatic access(input logic wr, input logic grp, input logic [7:0] a,
                        input logic [31:0] d, input int l, output logic [31:0] rd);
    logic ok;
    logic [31:0] v;
    lat = l;
    hwr(3'd1, d);
    hwr(3'd0, {21'd0, grp, ~wr, wr, a});
    wait_ack("R4", ok);
    hrd(3'd4, rd);
    hwr(3'd0, 32'd0);
    hrd(3'd5, v);
    chk("R5", v, 32'd0);
  endtask

  // vector: {wr, grp, addr[7:0], data[31:0], lat[3:0]}
  localparam int NV = 10;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h43, 32'h00200188, 4'd0},
    {1'b1, 1'b1, 8'h43, 32'h00200189, 4'd3},
    {1'b1, 1'b0, 8'h5A, 32'h0000A061, 4'd7},
    {1'b1, 1'b0, 8'h52, 32'h20000000, 4'd1},
    {1'b1, 1'b0, 8'h60, 32'h28E80000, 4'd15},
    {1'b0, 1'b0, 8'h43, 32'h00200188, 4'd2},
    {1'b0, 1'b1, 8'h43, 32'h00200189, 4'd0},
    {1'b0, 1'b0, 8'h60, 32'h28E80000, 4'd9},
    {1'b0, 1'b0, 8'h5A, 32'h0000A061, 4'd4},
    {1'b0, 1'b1, 8'h52, 32'h00000000, 4'd5}
  };

  initial begin
    logic [31:0] v, keep;
    logic ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      hrd(3'(i), v);
      chk("R1 register", v, 32'd0);
    end
    chk("R1 req", 32'(phy_req), 32'd0);
    chk("R1 rst lines", 32'({phy_rst_hard, phy_rst_soft}), 32'd0);

    // R9 reset lines
    hwr(3'd3, 32'd3);
    chk("R9 both", 32'({phy_rst_hard, phy_rst_soft}), 32'd3);
    hwr(3'd3, 32'd1);
    chk("R9 soft only", 32'({phy_rst_hard, phy_rst_soft}), 32'd1);
    hwr(3'd3, 32'd0);

    // R7 lane disabled
    hwr(3'd1, 32'h1234);
    hwr(3'd0, 32'h143);
    repeat (5) @(negedge clk);
    chk("R7 req", 32'(phy_req), 32'd0);
    hrd(3'd5, v);
    chk("R7 ack", v, 32'd0);
    hwr(3'd0, 32'd0);
    hwr(3'd2, 32'd1);
    chk("R7 lane out", 32'(phy_lane), 32'd1);

    // R2 write request fields, R4 held during latency
    lat = 12;
    hwr(3'd1, 32'hCAFE0001);
    hwr(3'd0, 32'h543);
    chk("R2 req", 32'(phy_req), 32'd1);
    chk("R2 fields", {phy_wr, phy_grp, 22'd0, phy_addr}, {1'b1, 1'b1, 22'd0, 8'h43});
    chk("R2 data", phy_wdata, 32'hCAFE0001);
    repeat (4) @(negedge clk);
    chk("R4 held", 32'(phy_req), 32'd1);
    hrd(3'd5, v);
    chk("R4 no early ack", v, 32'd0);
    wait_ack("R4", ok);
    chk("R4 req dropped", 32'(phy_req), 32'd0);
    hwr(3'd0, 32'd0);

    // vector table: group writes/reads (R2, R3, R11)
    for (int k = 0; k < NV; k++) begin
      access(VEC[k][45], VEC[k][44], VEC[k][43:36], VEC[k][35:4], int'(VEC[k][3:0]), v);
      if (!VEC[k][45]) chk("R3 R11 readback", v, VEC[k][35:4]);
    end

    // R10 command while acknowledged
    lat = 1;
    hwr(3'd0, 32'h243);
    wait_ack("R10", ok);
    hrd(3'd4, keep);
    chk("R3 captured", keep, 32'h00200188);
    hwr(3'd0, 32'h260);
    repeat (6) @(negedge clk);
    chk("R10 no req", 32'(phy_req), 32'd0);
    hrd(3'd5, v);
    chk("R10 R5 ack held", v, 32'd1);
    hrd(3'd4, v);
    chk("R10 readback kept", v, keep);
    hwr(3'd0, 32'd0);

    // R6 both bits / neither bit
    hwr(3'd0, 32'h343);
    repeat (5) @(negedge clk);
    chk("R6 both", 32'(phy_req), 32'd0);
    hwr(3'd0, 32'd0);
    hwr(3'd0, 32'h443);
    repeat (5) @(negedge clk);
    chk("R6 neither", 32'(phy_req), 32'd0);
    hrd(3'd5, v);
    chk("R6 ack", v, 32'd0);
    hwr(3'd0, 32'd0);

    // R8 command while hard reset held
    hwr(3'd3, 32'd2);
    hwr(3'd0, 32'h243);
    repeat (5) @(negedge clk);
    chk("R8 blocked", 32'(phy_req), 32'd0);
    hrd(3'd5, v);
    chk("R8 ack low", v, 32'd0);
    hwr(3'd0, 32'd0);
    hwr(3'd3, 32'd0);

    // R8 abort in flight
    lat = 30;
    hwr(3'd0, 32'h260);
    chk("R8 started", 32'(phy_req), 32'd1);
    hwr(3'd3, 32'd2);
    @(negedge clk);
    chk("R8 abort req", 32'(phy_req), 32'd0);
    repeat (40) @(negedge clk);
    hrd(3'd5, v);
    chk("R8 abort ack", v, 32'd0);
    hwr(3'd0, 32'd0);
    hwr(3'd3, 32'd0);

    // R5 recovery: fresh access works after the abort
    access(1'b0, 1'b0, 8'h60, 32'd0, 2, v);
    chk("R5 R3 after abort", v, 32'h28E80000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule